// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block holds the digital control of an 8-bit successive-approximation analog-to-digital converter with an 8-way input selector. A start request is taken only while the block is idle. When it is accepted, the block captures the channel number and the converter-rate choice. It then steers the analog selector, holds a sample window, and walks a trial code on the external DAC one bit at a time, starting at the most significant bit. For each trial it reads a single comparator bit.

Every conversion takes a fixed 160 converter-clock cycles, and the first 12 of these are the sample window. The converter clock runs either at the system clock rate or at half of it. At the end of the conversion the result register is loaded, the done flag is set and a one-cycle interrupt pulse is raised. The comparator, the DAC and the sample-and-hold circuit are outside this block.

Top module: `sar_seq`

## Requirements
- R1: After reset, busy_o, done_o, irq_o and sample_o are 0, and result_o, mux_sel_o and dac_code_o are all 00h / 0.
- R2: A start_i seen high at a clock edge while idle is accepted. From the next cycle busy_o is 1 and done_o is 0. busy_o stays 1 until the edge that writes the result.
- R3: With half_clk_i = 0 latched, the result write (done_o set, irq_o high) becomes visible exactly 160 system-clock cycles after the accepting edge.
- R4: With half_clk_i = 1 latched, the converter advances every second system clock, and the result write becomes visible exactly 320 system-clock cycles after the accepting edge.
- R5: sample_o is 1 for the first 12 converter cycles of a conversion: 12 system cycles at full rate and 24 at half rate. It is 1 from the cycle after the accepting edge and never outside busy_o.
- R6: After the sample window, bits 7 down to 0 are tried in turn, with the trial bit set to 1 on dac_code_o. The bit is kept when cmp_i = 1 (input at or above the DAC level) and cleared otherwise. With an ideal comparator, the result equals the input code, where 00h is the lowest level and FFh the highest.
- R7: When the result register updates, done_o goes to 1 and irq_o is high for exactly one cycle. result_o holds its value until the next update.
- R8: A start_i while busy_o is 1 is ignored. The running conversion keeps its timing and produces a single result.
- R9: mux_sel_o shows the channel number latched at the accepted start. Changes of chan_i or half_clk_i during a conversion take effect only at the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request |
| chan_i | input | 3 | Channel number for the next conversion |
| half_clk_i | input | 1 | 1 selects a converter clock at half the system rate |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| mux_sel_o | output | 3 | Analog selector channel |
| dac_code_o | output | 8 | Trial code to the DAC |
| sample_o | output | 1 | Sample window active |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Result valid since the last conversion |
| irq_o | output | 1 | One-cycle pulse on result write |
| result_o | output | 8 | Conversion result |

## Verification
The assertions check these properties on every cycle:
- the interrupt is a single-cycle pulse that only occurs with done set and busy clear;
- the result changes only on that pulse;
- done clears after an accepted start;
- the selector stays stable for the whole of a busy period;
- the sample window lies inside busy and opens right after the start;
- the conversion counter stays in range.

Only the bench scenarios can show the rest: the exact 160 and 320 cycle lengths, the 12 and 24 cycle sample windows, the correct code for inputs at both ends and in the middle of the range, that a start during a conversion does not disturb it, and that a mid-conversion change of channel or rate first shows at the following start.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SAMPLE,
    PH_APPROX,
    PH_PAD
  } sar_phase_e;

endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  input  logic half_i,
  output logic tick_o
);

  logic ph_q;
  logic ph_d;
  logic ph_en;

  assign ph_en = restart_i | run_i;

  always_comb begin
    if (restart_i) ph_d = 1'b0;
    else           ph_d = ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ph_q <= 1'b0;
    else if (ph_en) ph_q <= ph_d;
  end

  assign tick_o = half_i ? ph_q : 1'b1;

endmodule

// File: rtl/sar_timer.sv
module sar_timer
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS   = 8,
  parameter int SAMPLE_CYC = 12,
  parameter int SLOT_CYC   = 4,
  parameter int TOTAL_CYC  = 160,
  localparam int CNT_W     = $clog2(TOTAL_CYC),
  localparam int SLOT_W    = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1,
  localparam int BIT_W     = $clog2(RES_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             tick_i,
  output logic             busy_o,
  output sar_phase_e       phase_o,
  output logic [BIT_W-1:0] bit_o,
  output logic             slot_end_o,
  output logic             finish_o
);

  localparam int APPROX_END = SAMPLE_CYC + RES_BITS * SLOT_CYC;

  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              step_en;
  logic              in_approx;

  assign step_en   = accept_i | (busy_q & tick_i);
  assign in_approx = busy_q && (cnt_q >= CNT_W'(SAMPLE_CYC)) && (cnt_q < CNT_W'(APPROX_END));
  assign finish_o  = busy_q & tick_i & (cnt_q == CNT_W'(TOTAL_CYC - 1));
  assign slot_end_o = in_approx & tick_i & (slot_q == SLOT_W'(SLOT_CYC - 1));

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    slot_d = slot_q;
    bit_d  = bit_q;
    if (accept_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      slot_d = '0;
      bit_d  = BIT_W'(RES_BITS - 1);
    end else begin
      if (finish_o) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      if (in_approx) begin
        if (slot_end_o) begin
          slot_d = '0;
          bit_d  = bit_q - 1'b1;
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      slot_q <= '0;
      bit_q  <= '0;
    end else if (step_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
      bit_q  <= bit_d;
    end
  end

  always_comb begin
    if (!busy_q)                          phase_o = PH_IDLE;
    else if (cnt_q < CNT_W'(SAMPLE_CYC))  phase_o = PH_SAMPLE;
    else if (in_approx)                   phase_o = PH_APPROX;
    else                                  phase_o = PH_PAD;
  end

  assign busy_o = busy_q;
  assign bit_o  = bit_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < CNT_W'(TOTAL_CYC))) else $error("counter out of range"); // R3

  AST_SAMPLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> (phase_o == PH_SAMPLE)) else $error("sample not first"); // R5

endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
  parameter int RES_BITS = 8,
  localparam int BIT_W   = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept_i,
  input  logic                approx_i,
  input  logic [BIT_W-1:0]    bit_i,
  input  logic                slot_end_i,
  input  logic                finish_i,
  input  logic                cmp_i,
  output logic [RES_BITS-1:0] dac_o,
  output logic [RES_BITS-1:0] result_o,
  output logic                done_o,
  output logic                irq_o
);

  logic [RES_BITS-1:0] code_q, code_d;
  logic [RES_BITS-1:0] res_q;
  logic                done_q, done_d;
  logic                irq_q;
  logic                code_en;
  logic                done_en;
  logic [RES_BITS-1:0] trial_mask;

  assign code_en = accept_i | slot_end_i;
  assign done_en = accept_i | finish_i;

  always_comb begin
    code_d = code_q;
    if (accept_i) code_d = '0;
    else          code_d[bit_i] = cmp_i;
  end

  assign done_d = finish_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        res_q <= '0;
    else if (finish_i) res_q <= code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       done_q <= 1'b0;
    else if (done_en) done_q <= done_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= finish_i;
  end

  always_comb begin
    trial_mask = '0;
    if (approx_i) trial_mask[bit_i] = 1'b1;
  end

  assign dac_o    = code_q | trial_mask;
  assign result_o = res_q;
  assign done_o   = done_q;
  assign irq_o    = irq_q;

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q) else $error("irq longer than one cycle"); // R7

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_q |-> $stable(res_q)) else $error("result changed without irq"); // R7

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> !done_q) else $error("done not cleared on start"); // R2

endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS   = 8,
  parameter int CHAN_BITS  = 3,
  parameter int SAMPLE_CYC = 12,
  parameter int SLOT_CYC   = 4,
  parameter int TOTAL_CYC  = 160,
  localparam int BIT_W     = $clog2(RES_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [CHAN_BITS-1:0] chan_i,
  input  logic                 half_clk_i,
  input  logic                 cmp_i,
  output logic [CHAN_BITS-1:0] mux_sel_o,
  output logic [RES_BITS-1:0]  dac_code_o,
  output logic                 sample_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 irq_o,
  output logic [RES_BITS-1:0]  result_o
);

  logic                 busy;
  logic                 accept;
  logic                 tick;
  logic                 slot_end;
  logic                 finish;
  logic [BIT_W-1:0]     bit_idx;
  sar_phase_e           phase;
  logic [CHAN_BITS-1:0] chan_q;
  logic                 half_q;

  assign accept = start_i & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      half_q <= 1'b0;
    end else if (accept) begin
      chan_q <= chan_i;
      half_q <= half_clk_i;
    end
  end

  sar_tick_gen u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (accept),
    .run_i     (busy),
    .half_i    (half_q),
    .tick_o    (tick)
  );

  sar_timer #(
    .RES_BITS   (RES_BITS),
    .SAMPLE_CYC (SAMPLE_CYC),
    .SLOT_CYC   (SLOT_CYC),
    .TOTAL_CYC  (TOTAL_CYC)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (accept),
    .tick_i     (tick),
    .busy_o     (busy),
    .phase_o    (phase),
    .bit_o      (bit_idx),
    .slot_end_o (slot_end),
    .finish_o   (finish)
  );

  sar_code_reg #(
    .RES_BITS (RES_BITS)
  ) u_code (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (accept),
    .approx_i   (phase == PH_APPROX),
    .bit_i      (bit_idx),
    .slot_end_i (slot_end),
    .finish_i   (finish),
    .cmp_i      (cmp_i),
    .dac_o      (dac_code_o),
    .result_o   (result_o),
    .done_o     (done_o),
    .irq_o      (irq_o)
  );

  assign mux_sel_o = chan_q;
  assign sample_o  = (phase == PH_SAMPLE);
  assign busy_o    = busy;

  AST_MUX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mux_sel_o)) else $error("selector moved while busy"); // R9

  AST_SAMPLE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> busy_o) else $error("sample outside busy"); // R5

  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (done_o && !busy_o)) else $error("irq without done"); // R7

endmodule

// File: tb/sim_sar_seq.sv
module sim_sar_seq;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [2:0] chan_i;
  logic       half_clk_i;
  logic       cmp_i;
  logic [2:0] mux_sel_o;
  logic [7:0] dac_code_o;
  logic       sample_o;
  logic       busy_o;
  logic       done_o;
  logic       irq_o;
  logic [7:0] result_o;
  logic [7:0] vin;

  int  n_tests;
  int  n_fail;
  longint cyc;

  typedef struct {
    logic [7:0] res;
    longint     cycles;
    longint     t0;
  } exp_t;

  exp_t exp_q[$];

  sar_seq u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .chan_i     (chan_i),
    .half_clk_i (half_clk_i),
    .cmp_i      (cmp_i),
    .mux_sel_o  (mux_sel_o),
    .dac_code_o (dac_code_o),
    .sample_o   (sample_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .irq_o      (irq_o),
    .result_o   (result_o)
  );

  assign cmp_i = (vin >= dac_code_o);

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every interrupt pulse
  always @(negedge clk) begin
    if (rst_n && irq_o) begin
      if (exp_q.size() == 0) begin
        check(0, "R8 unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(result_o == e.res, "R6 result code", result_o, e.res);
        check((cyc - e.t0) == e.cycles, "R3/R4 conversion length", cyc - e.t0, e.cycles);
        check(done_o && !busy_o, "R7 done at irq", {done_o, busy_o}, 2);
      end
    end
  end

  task automatic run_conv(input logic [7:0] v, input logic h, input logic [2:0] ch,
                          input int ign_at, input int chg_at);
    exp_t e;
    int k;
    int samp;
    int muxbad;
    longint exp_len;
    exp_len = h ? 320 : 160;
    @(negedge clk);
    vin = v;
    half_clk_i = h;
    chan_i = ch;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    e.res = v;
    e.cycles = exp_len;
    e.t0 = cyc;
    exp_q.push_back(e);
    check(busy_o && !done_o, "R2 busy set, done cleared", {busy_o, done_o}, 2);
    k = 0;
    samp = sample_o ? 1 : 0;
    muxbad = (mux_sel_o != ch) ? 1 : 0;
    while (!done_o && k < 1000) begin
      @(posedge clk);
      @(negedge clk);
      k++;
      if (start_i) start_i = 1'b0;
      if (sample_o) samp++;
      if (mux_sel_o != ch) muxbad++;
      if (!done_o) check(busy_o, "R2 busy held", busy_o, 1);
      if (k == ign_at) begin
        start_i = 1'b1;
        chan_i = ~ch;
      end
      if (k == chg_at) begin
        half_clk_i = ~h;
        chan_i = ch + 3'd1;
      end
    end
    if (ign_at > 0) check(k == exp_len, "R8 start while busy ignored", k, exp_len);
    else            check(k == exp_len, "R3/R4 length seen by driver", k, exp_len);
    if (chg_at > 0) check(k == exp_len, "R9 rate change deferred", k, exp_len);
    check(samp == (h ? 24 : 12), "R5 sample window", samp, h ? 24 : 12);
    check(muxbad == 0, "R9 selector held", muxbad, 0);
    @(posedge clk);
    @(negedge clk);
    check(!irq_o, "R7 irq one cycle", irq_o, 0);
    check(result_o == v && done_o && !busy_o, "R7 result held", result_o, v);
  endtask

  initial begin
    #(4 * 150000);
    check(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0;
    n_fail = 0;
    rst_n = 1'b0;
    start_i = 1'b0;
    chan_i = 3'd0;
    half_clk_i = 1'b0;
    vin = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o && !irq_o && !sample_o, "R1 reset flags",
          {busy_o, done_o, irq_o, sample_o}, 0);
    check(result_o == 8'h00, "R1 reset result", result_o, 0);
    check(mux_sel_o == 3'd0, "R1 reset selector", mux_sel_o, 0);
    check(dac_code_o == 8'h00, "R1 reset dac", dac_code_o, 0);

    run_conv(8'hA5, 1'b0, 3'd5, 0, 0);
    run_conv(8'h00, 1'b0, 3'd1, 0, 0);   // R6 lowest code
    run_conv(8'hFF, 1'b0, 3'd7, 0, 0);   // R6 highest code
    run_conv(8'h80, 1'b1, 3'd3, 0, 0);   // R4 half rate
    run_conv(8'h7F, 1'b1, 3'd0, 0, 0);
    run_conv(8'h3C, 1'b0, 3'd4, 50, 0);  // R8 start during conversion
    run_conv(8'hC3, 1'b1, 3'd6, 200, 0); // R8 at half rate
    run_conv(8'h5A, 1'b0, 3'd2, 0, 30);  // R9 channel and rate change mid-run
    check(chan_i == 3'd3 && half_clk_i == 1'b1, "R9 bench setup", chan_i, 3);
    run_conv(8'h01, 1'b1, 3'd3, 0, 0);   // R9 new values take effect at next start

    repeat (20) @(negedge clk);
    check(result_o == 8'h01 && done_o, "R7 result held while idle", result_o, 1);
    check(exp_q.size() == 0, "R7 every result signalled", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule